// File: doc/BRIEF.md
# Byte-wide ALU with registered status flags

This block is the arithmetic and logic unit of a small accumulator machine. Every cycle it takes an accumulator byte, a second operand byte and a four-bit operation code. It forms an eight-bit result from these combinationally, together with the held carry flag. It also drives a separate write-enable for each of the three status flags: carry (C), half carry (AC) and signed overflow (OV). The flag register inside the block takes its new values on the rising clock edge, and only for the flags whose enable is high.

The surrounding core fetches the operands, decodes addressing modes and decides where the result goes. For the compare operation, the core uses the not-equal output to steer its branch and then tests the carry for ordering. Operations that need no flag update leave the flags as they were. The core can therefore chain several byte operations between flag tests.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) gives result = (acc + opnd) mod 256. It sets C to the carry out of bit 7 and AC to the carry out of bit 3, and clears each flag when there is no such carry.
- R2: Code 1 (add with carry) gives result = (acc + opnd + C) mod 256. Its C and AC rules are the same as for R1.
- R3: For codes 0 and 1, OV equals the carry out of bit 6 XOR the carry out of bit 7. For example, 0xC3 + 0xAA gives 0x6D with C=1, OV=1 and AC=0. With C already set, code 1 on the same operands gives 0x6E with the same flags.
- R4: Code 2 (subtract with borrow) gives result = (acc - opnd - C) mod 256. It sets C on a borrow out of bit 7, AC on a borrow out of bit 3, and OV on signed overflow.
- R5: Code 3 is AND, code 4 is OR and code 5 is XOR. Code 6 forces 0x00. Code 7 gives the one's complement. None of these changes any flag.
- R6: Code 8 rotates left and code 10 rotates right, with no flag change. Code 9 rotates left and code 11 rotates right through C as a ninth bit; these change only C.
- R7: Code 12 exchanges bits 7:4 with bits 3:0 and changes no flag.
- R8: Code 13 increments and code 14 decrements, both wrapping modulo 256, and neither changes any flag.
- R9: Code 15 (compare) returns acc unchanged as the result and raises neq_o when acc differs from opnd. It sets C exactly when acc < opnd as unsigned numbers and leaves AC and OV alone. For every other code, neq_o is 0.
- R10: The write-enables are as follows: all three for codes 0 to 2, only the carry enable for codes 9, 11 and 15, and none for the other codes. A flag register bit changes at a clock edge only when its enable is high.
- R11: While reset is held, and after it is released, C, AC and OV read 0 until an enabled update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| neq_o | output | 1 | Compare: operands differ |
| cy_we_o | output | 1 | Carry write-enable for this operation |
| ac_we_o | output | 1 | Half-carry write-enable |
| ov_we_o | output | 1 | Overflow write-enable |
| cy_o | output | 1 | Registered carry flag |
| ac_o | output | 1 | Registered half-carry flag |
| ov_o | output | 1 | Registered overflow flag |

## Verification
The assertions assume that op_i, acc_i and opnd_i are stable around the rising edge and never unknown after reset. They also assume that a flag update belongs to whatever operation is present at that edge. The stimulus applies a new operation just after each falling edge and holds it through the following rising edge. It draws every code from the full 4-bit range, so no undefined encoding exists. Directed cases cover carry and borrow at the nibble and byte boundaries, the wrap of increment and decrement, and compares with equal, smaller and larger operands.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_AND  = 4'd3,
    OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_CLR  = 4'd6,  OP_CPL  = 4'd7,
    OP_RL   = 4'd8,  OP_RLC  = 4'd9,  OP_RR   = 4'd10, OP_RRC  = 4'd11,
    OP_SWAP = 4'd12, OP_INC  = 4'd13, OP_DEC  = 4'd14, OP_CMP  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0]   full_w, fa, fb, fc;
  logic [HALF:0]     low_w, la, lb, lc;
  logic [DATA_W-1:0] top_w, ta, tb, tc;

  always_comb begin
    fa = {1'b0, a_i};
    fb = {1'b0, b_i};
    fc = {{DATA_W{1'b0}}, cin_i};
    la = {1'b0, a_i[HALF-1:0]};
    lb = {1'b0, b_i[HALF-1:0]};
    lc = {{HALF{1'b0}}, cin_i};
    ta = {1'b0, a_i[DATA_W-2:0]};
    tb = {1'b0, b_i[DATA_W-2:0]};
    tc = {{(DATA_W-1){1'b0}}, cin_i};
    if (sub_i) begin
      full_w = fa - fb - fc;
      low_w  = la - lb - lc;
      top_w  = ta - tb - tc;
    end else begin
      full_w = fa + fb + fc;
      low_w  = la + lb + lc;
      top_w  = ta + tb + tc;
    end
    res_o = full_w[DATA_W-1:0];
    cy_o  = full_w[DATA_W];
    ac_o  = low_w[HALF];
    ov_o  = full_w[DATA_W] ^ top_w[DATA_W-1];
  end
endmodule

// File: rtl/byte_alu_unary.sv
module byte_alu_unary
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    res_o = a_i;
    cy_o  = cin_i;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
      OP_RLC: begin
        res_o = {a_i[DATA_W-2:0], cin_i};
        cy_o  = a_i[DATA_W-1];
      end
      OP_RRC: begin
        res_o = {cin_i, a_i[DATA_W-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
      OP_INC:  res_o = a_i + 1'b1;
      OP_DEC:  res_o = a_i - 1'b1;
      OP_CMP:  cy_o  = (a_i < b_i);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  flags_t q_r, q_nx;

  always_comb begin
    q_nx = q_r;
    if (we_i.cy) q_nx.cy = d_i.cy;
    if (we_i.ac) q_nx.ac = d_i.ac;
    if (we_i.ov) q_nx.ov = d_i.ov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q_o = q_r;

  p_cy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i.cy |=> $stable(q_r.cy));
  p_ac_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i.ac |=> $stable(q_r.ac));
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              neq_o,
  output logic              cy_we_o,
  output logic              ac_we_o,
  output logic              ov_we_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  alu_op_e           op;
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic              is_arith, arith_cin;
  logic [DATA_W-1:0] arith_res, un_res;
  logic              arith_cy, arith_ac, arith_ov, un_cy;
  flags_t            we, nxt, cur;

  assign op = alu_op_e'(op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign is_arith  = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
  assign arith_cin = (op == OP_ADD) ? 1'b0 : cur.cy;

  byte_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(arith_cin), .sub_i(op == OP_SUBB),
    .res_o(arith_res), .cy_o(arith_cy), .ac_o(arith_ac), .ov_o(arith_ov)
  );

  byte_alu_unary #(.DATA_W(DATA_W)) u_unary (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cin_i(cur.cy),
    .res_o(un_res), .cy_o(un_cy)
  );

  always_comb begin
    we.cy = is_arith || (op == OP_RLC) || (op == OP_RRC) || (op == OP_CMP);
    we.ac = is_arith;
    we.ov = is_arith;
    nxt.cy = is_arith ? arith_cy : un_cy;
    nxt.ac = arith_ac;
    nxt.ov = arith_ov;
  end

  byte_alu_flags u_flags (
    .clk(clk), .rst_n(rst_q_n), .we_i(we), .d_i(nxt), .q_o(cur)
  );

  assign result_o = is_arith ? arith_res : un_res;
  assign neq_o    = (op == OP_CMP) && (acc_i != opnd_i);
  assign cy_we_o  = we.cy;
  assign ac_we_o  = we.ac;
  assign ov_we_o  = we.ov;
  assign cy_o     = cur.cy;
  assign ac_o     = cur.ac;
  assign ov_o     = cur.ov;

  p_cmp_keep_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_CMP) |-> (result_o == acc_i));
  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_CLR) |-> (result_o == '0 && !cy_we_o));
  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_INC && acc_i == '1) |-> (result_o == '0));
  p_ov_group_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ov_we_o |-> (cy_we_o && ac_we_o));
  p_ov_track_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    ov_we_o |=> (ov_o == $past(arith_ov)));
endmodule

// File: tb/byte_alu_test.sv
`timescale 1ns/1ps
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] acc_i, opnd_i, result_o;
  logic       neq_o, cy_we_o, ac_we_o, ov_we_o, cy_o, ac_o, ov_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic m_cy, m_ac, m_ov;

  always #2.5 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .result_o(result_o), .neq_o(neq_o), .cy_we_o(cy_we_o), .ac_we_o(ac_we_o),
    .ov_we_o(ov_we_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";  1: return "R2";  2: return "R4";
      3, 4, 5, 6, 7: return "R5";
      8, 9, 10, 11: return "R6";
      12: return "R7"; 13, 14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input int op, input int a, input int b);
    int res, neq, wc, wa, wo, nc, na, no, s, ci;
    string rq;
    rq = req_of(op);
    ci = m_cy;
    neq = 0; wc = 0; wa = 0; wo = 0; nc = m_cy; na = m_ac; no = m_ov; res = a;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        res = (a + b + ci) & 255;
        nc = (a + b + ci) > 255;
        na = ((a & 15) + (b & 15) + ci) > 15;
        s = $signed(8'(a)) + $signed(8'(b)) + ci;
        no = (s > 127) || (s < -128);
        wc = 1; wa = 1; wo = 1;
      end
      2: begin
        res = (a - b - ci) & 255;
        nc = a < (b + ci);
        na = (a & 15) < ((b & 15) + ci);
        s = $signed(8'(a)) - $signed(8'(b)) - ci;
        no = (s > 127) || (s < -128);
        wc = 1; wa = 1; wo = 1;
      end
      3: res = a & b;
      4: res = a | b;
      5: res = a ^ b;
      6: res = 0;
      7: res = 255 - a;
      8: res = ((a * 2) & 255) | (a / 128);
      9: begin res = ((a * 2) & 255) | ci; nc = a / 128; wc = 1; end
      10: res = (a / 2) | ((a % 2) * 128);
      11: begin res = (a / 2) | (ci * 128); nc = a % 2; wc = 1; end
      12: res = ((a % 16) * 16) + (a / 16);
      13: res = (a + 1) % 256;
      14: res = (a + 255) % 256;
      default: begin res = a; neq = (a != b); nc = (a < b); wc = 1; end
    endcase
    @(negedge clk);
    op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b);
    #1;
    chk({rq, " result"}, result_o, res);
    chk({"R9 neq"}, neq_o, neq);
    chk({"R10 we"}, {cy_we_o, ac_we_o, ov_we_o}, (wc * 4) + (wa * 2) + wo);
    if (wc != 0) m_cy = nc[0];
    if (wa != 0) m_ac = na[0];
    if (wo != 0) m_ov = no[0];
    @(posedge clk); #1;
    chk({rq, " C"}, cy_o, m_cy);
    chk({(op < 2) ? "R3" : rq, " OV"}, ov_o, m_ov);
    chk({rq, " AC"}, ac_o, m_ac);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hA1B2));
    rst_n = 1'b0; op_i = 4'd3; acc_i = 8'h00; opnd_i = 8'h00;
    m_cy = 0; m_ac = 0; m_ov = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset C", cy_o, 0);
    chk("R11 reset AC", ac_o, 0);
    chk("R11 reset OV", ov_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    chk("R11 after release", {cy_o, ac_o, ov_o}, 0);
    // directed corners
    run(0, 'hC3, 'hAA);   // R3 example: 6D, C=1 OV=1 AC=0
    run(1, 'hC3, 'hAA);   // R3 with carry set: 6E
    run(0, 'h0F, 'h01);   // R1 half carry only
    run(0, 'h00, 'h00);   // R1 clears flags
    run(2, 'h80, 'h01);   // R4 signed overflow, nibble borrow
    run(2, 'h00, 'h01);   // R4 full borrow
    run(2, 'h10, 'h0F);   // R4 uses the borrow
    run(7, 'h5C, 'h00);   // R5 one's complement to A3
    run(3, 'hC3, 'h55);   // R5 AND to 41
    run(6, 'h9E, 'h33);   // R5 clear
    run(9, 'h81, 'h00);   // R6 rotate left through carry
    run(11, 'h01, 'h00);  // R6 rotate right through carry
    run(8, 'h81, 'h00);   // R6 plain rotate
    run(12, 'h3C, 'h00);  // R7 swap
    run(13, 'hFF, 'h00);  // R8 wrap up
    run(14, 'h00, 'h00);  // R8 wrap down
    run(15, 'h34, 'h34);  // R9 equal
    run(15, 'h34, 'h56);  // R9 less
    run(15, 'hF0, 'h0F);  // R9 greater
    for (int i = 0; i < 3000; i++)
      run(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule